// File: doc/BRIEF.md
# Mailbox Sender Frame with Transmit-Complete Interrupt

This block is the transmit side of a mailbox. Software writes bits into a bank of 32-bit channel windows, and the receiver sees them through a flat status bus. The receiver consumes a message by clearing bits. Software learns that a transfer has finished in one of two ways: it polls a window's status until the status reads zero, or it waits for the interrupt.

Every window records a sticky transmit-complete flag whenever any of its status bits falls from 1 to 0. Each flag is cleared by writing 1 to it and is gated by a per-window enable. The enabled flags are gathered into a combined bitmap that drives a single interrupt line. An access request output and a synchronised ready input let software wake the receiver before it uses the channel.

Register access is a single-cycle write strobe with an asynchronous read port. The read data is a combinational decode of the address.

Top module: `mbx_send_frame`

## Requirements
- R1: Window w occupies byte offsets w*0x20 up to w*0x20+0x1F. In each window, offset +0x00 returns the status word and ignores writes, +0x0C is status-set, +0x10 returns the interrupt flag in bit 0, +0x14 is interrupt-clear and +0x18 holds the interrupt enable in bit 0.
- R2: A write to a window's status-set offset ORs the written word into that window's status. The write takes effect at the clock edge that samples it.
- R3: A 1 in the receiver clear mask clears the matching status bit at the same edge. A window whose status reads zero is idle. The status output bus carries window w in bits [32w+31:32w].
- R4: A window's interrupt flag sets at any edge where one or more of its status bits go from 1 to 0. The flag then stays set. A completion at the same edge as an interrupt-clear write leaves the flag set.
- R5: Writing a word with bit 0 set to a window's interrupt-clear offset drops its flag at that edge, provided no completion happens at that edge. Writing a word with bit 0 clear has no effect.
- R6: The four words at 0xFA0, 0xFA4, 0xFA8 and 0xFAC form a combined bitmap, with window w at bit w%32 of word w/32. A window's bit reads 1 only when both its flag and its enable are set. Bit 2 of the frame enable at 0xF98 is readable. The interrupt output is high exactly when that bit is set and the bitmap is non-zero. Bit 2 of 0xF90 reports whether the bitmap is non-zero.
- R7: Bit 0 of 0xF88 is a read/write access request that drives the request output. 0xF8C bit 0 returns the ready input after a two-flop synchroniser, so it is visible two edges after the input changes.
- R8: After reset, all status words, interrupt flags, enables, the frame enable and the access request are zero.
- R9: 0xF80 returns the number of windows in bits 6:0. Writes to 0xF80 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| rx_clr_mask | input | NUM_WIN*32 | Receiver clear request, window w in bits [32w+31:32w] |
| win_status | output | NUM_WIN*32 | Status words seen by the receiver |
| acc_req | output | 1 | Access request to the receiver |
| acc_ack | input | 1 | Asynchronous ready from the receiver |
| tx_irq | output | 1 | Combined transmit-complete interrupt |

## Verification
The assertions assume that bus_wr and rx_clr_mask are synchronous to clk and hold steady around the sampling edge. They also assume that acc_ack is the only asynchronous input. The bench changes every input at the falling edge, and it changes acc_ack only there as well. The bench pairs a completion with an interrupt-clear write in the same cycle, so that the case where the set must win is exercised.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   localparam int unsigned WORD_W      = 32;
   localparam int unsigned MAX_WIN     = 124;
   localparam int unsigned COMB_WORDS  = 4;
   localparam int unsigned WIN_STRIDE  = 32;
   // in-window offsets
   localparam logic [4:0] OFF_STAT  = 5'h00;
   localparam logic [4:0] OFF_SET   = 5'h0C;
   localparam logic [4:0] OFF_IST   = 5'h10;
   localparam logic [4:0] OFF_ICLR  = 5'h14;
   localparam logic [4:0] OFF_IEN   = 5'h18;
   // frame offsets
   localparam logic [11:0] FR_CFG   = 12'hF80;
   localparam logic [11:0] FR_RESP  = 12'hF84;
   localparam logic [11:0] FR_REQ   = 12'hF88;
   localparam logic [11:0] FR_RDY   = 12'hF8C;
   localparam logic [11:0] FR_IST   = 12'hF90;
   localparam logic [11:0] FR_ICLR  = 12'hF94;
   localparam logic [11:0] FR_IEN   = 12'hF98;
   localparam logic [11:0] FR_COMB0 = 12'hFA0;
   localparam int unsigned COMB_EN_BIT = 2;
endpackage

// File: rtl/mbx_sync2.sv
module mbx_sync2 (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   logic stage1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stage1 <= 1'b0;
         q_sync <= 1'b0;
      end else begin
         stage1 <= d_async;
         q_sync <= stage1;
      end
   end

   AST_SYNC_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
      q_sync == $past(stage1)); // R7
endmodule

// File: rtl/mbx_win.sv
module mbx_win
   import mbx_pkg::*;
#(
   parameter int unsigned DW = WORD_W
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          set_we,
   input  logic          iclr_we,
   input  logic          ien_we,
   input  logic [DW-1:0] wdata,
   input  logic [DW-1:0] clr_mask,
   output logic [DW-1:0] status,
   output logic          ist,
   output logic          ien
);
   logic [DW-1:0] status_d;
   logic          fall;

   always_comb begin
      status_d = status & ~clr_mask;
      if (set_we) status_d = status_d | wdata;
   end

   assign fall = |(status & ~status_d);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status <= '0;
         ist    <= 1'b0;
         ien    <= 1'b0;
      end else begin
         status <= status_d;
         if (fall)                      ist <= 1'b1;
         else if (iclr_we && wdata[0])  ist <= 1'b0;
         if (ien_we)                    ien <= wdata[0];
      end
   end

   AST_SET_OR: assert property (@(posedge clk) disable iff (!rst_n)
      set_we |=> ((status & $past(wdata)) == $past(wdata))); // R2
   AST_CLR_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
      !set_we |=> ((status & $past(clr_mask)) == '0)); // R3
   AST_FALL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> ist); // R4
   AST_IST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ist && !(iclr_we && wdata[0])) |=> ist); // R4
   AST_ICLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (iclr_we && wdata[0] && !fall) |=> !ist); // R5
endmodule

// File: rtl/mbx_send_frame.sv
module mbx_send_frame
   import mbx_pkg::*;
#(
   parameter int unsigned NUM_WIN = 4,
   parameter int unsigned AW      = 12
)(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      bus_wr,
   input  logic [AW-1:0]             bus_addr,
   input  logic [WORD_W-1:0]         bus_wdata,
   output logic [WORD_W-1:0]         bus_rdata,
   input  logic [NUM_WIN*WORD_W-1:0] rx_clr_mask,
   output logic [NUM_WIN*WORD_W-1:0] win_status,
   output logic                      acc_req,
   input  logic                      acc_ack,
   output logic                      tx_irq
);
   localparam int unsigned IDX_W    = AW - 5;
   localparam int unsigned WIN_SPAN = NUM_WIN * WIN_STRIDE;
   localparam int unsigned COMB_W   = COMB_WORDS * WORD_W;

   if (NUM_WIN < 1 || NUM_WIN > MAX_WIN) begin : g_bad_num
      $error("mbx_send_frame: NUM_WIN out of range");
   end
   if (AW != 12) begin : g_bad_aw
      $error("mbx_send_frame: AW must be 12");
   end

   logic                 win_hit;
   logic [IDX_W-1:0]     widx;
   logic [4:0]           woff;
   logic [WORD_W-1:0]    stat  [NUM_WIN];
   logic [NUM_WIN-1:0]   ist_v, ien_v;
   logic [COMB_W-1:0]    comb_all;
   logic                 comb_en, acc_rdy, comb_any;

   assign win_hit = (32'(bus_addr) < WIN_SPAN);
   assign widx    = bus_addr[AW-1:5];
   assign woff    = bus_addr[4:0];

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      logic sel;
      assign sel = bus_wr && win_hit && (widx == IDX_W'(w));
      mbx_win #(.DW(WORD_W)) u_win (
         .clk      (clk),
         .rst_n    (rst_n),
         .set_we   (sel && woff == OFF_SET),
         .iclr_we  (sel && woff == OFF_ICLR),
         .ien_we   (sel && woff == OFF_IEN),
         .wdata    (bus_wdata),
         .clr_mask (rx_clr_mask[w*WORD_W +: WORD_W]),
         .status   (stat[w]),
         .ist      (ist_v[w]),
         .ien      (ien_v[w])
      );
      assign win_status[w*WORD_W +: WORD_W] = stat[w];
   end

   always_comb begin
      comb_all = '0;
      comb_all[NUM_WIN-1:0] = ist_v & ien_v;
   end
   assign comb_any = |comb_all;
   assign tx_irq   = comb_en && comb_any;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_req <= 1'b0;
         comb_en <= 1'b0;
      end else if (bus_wr) begin
         if (bus_addr == FR_REQ) acc_req <= bus_wdata[0];
         if (bus_addr == FR_IEN) comb_en <= bus_wdata[COMB_EN_BIT];
      end
   end

   mbx_sync2 u_rdy_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (acc_ack),
      .q_sync  (acc_rdy)
   );

   always_comb begin
      bus_rdata = '0;
      if (win_hit) begin
         for (int w = 0; w < NUM_WIN; w++) begin
            if (widx == IDX_W'(w)) begin
               case (woff)
                  OFF_STAT: bus_rdata = stat[w];
                  OFF_IST:  bus_rdata[0] = ist_v[w];
                  OFF_IEN:  bus_rdata[0] = ien_v[w];
                  default:  bus_rdata = '0;
               endcase
            end
         end
      end else begin
         case (bus_addr)
            FR_CFG:         bus_rdata[6:0] = 7'(NUM_WIN);
            FR_REQ:         bus_rdata[0] = acc_req;
            FR_RDY:         bus_rdata[0] = acc_rdy;
            FR_IST:         bus_rdata[COMB_EN_BIT] = comb_any;
            FR_IEN:         bus_rdata[COMB_EN_BIT] = comb_en;
            FR_COMB0:       bus_rdata = comb_all[0*WORD_W +: WORD_W];
            FR_COMB0 + 4:   bus_rdata = comb_all[1*WORD_W +: WORD_W];
            FR_COMB0 + 8:   bus_rdata = comb_all[2*WORD_W +: WORD_W];
            FR_COMB0 + 12:  bus_rdata = comb_all[3*WORD_W +: WORD_W];
            default:        bus_rdata = '0;
         endcase
      end
   end

   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      tx_irq |-> (comb_en && (ist_v & ien_v) != '0)); // R6
   AST_REQ_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == FR_REQ) |=> (acc_req == $past(bus_wdata[0]))); // R7
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_addr == FR_REQ) |=> $stable(acc_req)); // R7
endmodule

// File: tb/mbx_send_frame_bench.sv
module mbx_send_frame_bench;
   localparam int NW = 4;
   logic clk = 0, rst_n = 0;
   logic bus_wr = 0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic [NW*32-1:0] rx_clr_mask = '0, win_status;
   logic acc_req, acc_ack = 0, tx_irq;
   int n_run = 0, n_fail = 0;
   bit done = 0;

   always #5 clk = ~clk;

   mbx_send_frame #(.NUM_WIN(NW), .AW(12)) u_mbx_send_frame (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_clr_mask(rx_clr_mask),
      .win_status(win_status), .acc_req(acc_req), .acc_ack(acc_ack), .tx_irq(tx_irq));

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [11:0] a, logic [31:0] d);
      bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 0;
   endtask

   task automatic rd(logic [11:0] a, output logic [31:0] d);
      bus_addr = a; #1; d = bus_rdata;
   endtask

   task automatic rxclr(int w, logic [31:0] m);
      rx_clr_mask = '0; rx_clr_mask[w*32 +: 32] = m;
      @(negedge clk);
      rx_clr_mask = '0;
   endtask

   task automatic t_reset;
      logic [31:0] d;
      for (int w = 0; w < NW; w++) begin
         rd(12'(w*32), d);      chk("R8 status", d, 0);
         rd(12'(w*32+16), d);   chk("R8 ist", d, 0);
         rd(12'(w*32+24), d);   chk("R8 ien", d, 0);
      end
      rd(12'hF88, d); chk("R8 req", d, 0);
      chk("R8 req pin", 32'(acc_req), 0);
      chk("R8 irq", 32'(tx_irq), 0);
      rd(12'hF80, d); chk("R9 cfg", d, NW);
   endtask

   task automatic t_set_poll;
      logic [31:0] d;
      wr(12'h02C, 32'h0000_00F0);          // window 1 set
      wr(12'h02C, 32'h8000_0001);
      rd(12'h020, d); chk("R2 or", d, 32'h8000_00F1);
      chk("R3 bus", win_status[63:32], 32'h8000_00F1);
      rd(12'h000, d); chk("R1 w0 untouched", d, 0);
      wr(12'h020, 32'hFFFF_FFFF);          // RO status write ignored
      rd(12'h020, d); chk("R1 ro", d, 32'h8000_00F1);
      wr(12'hF80, 32'h7F);
      rd(12'hF80, d); chk("R9 ro", d, NW);
   endtask

   task automatic t_complete;
      logic [31:0] d;
      rxclr(1, 32'h0000_00F0);
      rd(12'h030, d); chk("R4 set on fall", d, 1);
      rd(12'h020, d); chk("R3 partial", d, 32'h8000_0001);
      wr(12'h034, 32'h0);
      rd(12'h030, d); chk("R5 bit0 zero no effect", d, 1);
      wr(12'h034, 32'h1);
      rd(12'h030, d); chk("R5 clear", d, 0);
      rxclr(1, 32'h0000_0100);             // clears nothing set: no fall
      rd(12'h030, d); chk("R4 no fall", d, 0);
      rxclr(1, 32'hFFFF_FFFF);
      rd(12'h020, d); chk("R3 idle", d, 0);
      rd(12'h030, d); chk("R4 sticky", d, 1);
      @(negedge clk);
      rd(12'h030, d); chk("R4 held", d, 1);
   endtask

   task automatic t_race;
      logic [31:0] d;
      wr(12'h014, 32'h1);                   // window 0 clear, nothing pending
      wr(12'h00C, 32'h5);
      rx_clr_mask = '0; rx_clr_mask[31:0] = 32'h4;
      bus_wr = 1; bus_addr = 12'h014; bus_wdata = 32'h1;
      @(negedge clk);
      bus_wr = 0; rx_clr_mask = '0;
      rd(12'h010, d); chk("R4 completion wins", d, 1);
      rd(12'h000, d); chk("R3 race status", d, 1);
   endtask

   task automatic t_comb;
      logic [31:0] d;
      wr(12'h04C, 32'h1);                   // window 2
      rxclr(2, 32'h1);
      wr(12'h02C, 32'h2);                   // window 1 (already pending)
      rd(12'hFA0, d); chk("R6 none enabled", d, 0);
      wr(12'h058, 32'h1);                   // enable window 2
      rd(12'hFA0, d); chk("R6 bitmap", d, 32'h4);
      rd(12'hFA4, d); chk("R6 word1", d, 0);
      chk("R6 irq off", 32'(tx_irq), 0);
      rd(12'hF90, d); chk("R6 frame ist", d, 32'h4);
      wr(12'hF98, 32'h4);
      rd(12'hF98, d); chk("R6 frame en", d, 32'h4);
      chk("R6 irq on", 32'(tx_irq), 1);
      wr(12'h054, 32'h1);
      chk("R6 irq drop", 32'(tx_irq), 0);
   endtask

   task automatic t_handshake;
      logic [31:0] d;
      wr(12'hF88, 32'h1);
      chk("R7 req", 32'(acc_req), 1);
      acc_ack = 1;
      @(negedge clk);
      rd(12'hF8C, d); chk("R7 one stage", d, 0);
      @(negedge clk);
      rd(12'hF8C, d); chk("R7 ready", d, 1);
      wr(12'hF88, 32'h0);
      rd(12'hF88, d); chk("R7 withdraw", d, 0);
      acc_ack = 0;
      @(negedge clk); @(negedge clk);
      rd(12'hF8C, d); chk("R7 ready low", d, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_set_poll();
      t_complete();
      t_race();
      t_comb();
      t_handshake();
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            n_run++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
         end
      join_any
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule